// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Sequencer

This controller decides when a volatile SRAM array is copied into its nonvolatile shadow (a STORE) and when the shadow is copied back into the array (a RECALL). It watches the host bus strobes and address, a supply-good comparator output and an active-low hardware store request. It keeps a flag that records whether the array has been written since the last nonvolatile operation. It also recognises a software command made of six consecutive reads to fixed addresses. When it accepts an operation it locks out the host and hands a one-cycle start pulse and a direction bit to the copy engine. The lockout lasts until the engine reports done.

Operations come from four sources. A rising supply-good starts a RECALL. A falling supply-good starts a STORE, but only if something was written. The hardware request and the software command sequence are the other two. A STORE that would copy an unchanged array is dropped without locking the host. The addresses, the command codes and every delay are parameters, and all delays are counted in clock cycles.

Top module: `nvsram_seq_ctrl`

## Requirements
- R1: After reset `busy` and `copy_start` are low, and both stay low until an accepted event occurs.
- R2: A read cycle is counted once, in the cycle where `ce_n`=0, `oe_n`=0 and `we_n`=1 first hold together; either `ce_n` or `oe_n` may be the strobe that completes it. Six counted reads at SEQ_ADDR0..SEQ_ADDR4 and then STORE_ADDR request a STORE (`copy_dir`=1). Ending the six reads with RECALL_ADDR instead requests a RECALL (`copy_dir`=0).
- R3: A counted read at the wrong address returns the matcher to its first step, and so does any write cycle (`ce_n`=0 with `we_n`=0, whatever `oe_n` is). The read that breaks the sequence does not count as the first step, even when its address is SEQ_ADDR0.
- R4: For a software command, `busy` is high from the cycle after the edge that samples the sixth read. `copy_start` rises SW_LAT cycles after that edge.
- R5: The written flag is set by a write cycle accepted while idle with supply good, and cleared when any operation completes. A STORE request from software, hardware or a falling supply is dropped when the flag is clear: no `copy_start`, and `busy` stays low.
- R6: `copy_start` is high for exactly one cycle. `busy` holds from acceptance to the edge that samples `copy_done`, and falls right after it. `copy_dir` does not change while `busy` is high.
- R7: While `busy` is high, host strobes are ignored. Writes do not set the written flag, and reads do not advance the command matcher.
- R8: A low-to-high change of `pwr_good` while idle makes `copy_start` rise on the next cycle with `copy_dir`=0, whatever the written flag holds.
- R9: A high-to-low change of `pwr_good` while idle, with the written flag set, makes `copy_start` rise on the next cycle with `copy_dir`=1. With the flag clear, nothing starts.
- R10: `hw_store_n` is accepted only after HW_PULSE_MIN consecutive low samples, at the edge that takes the last of them. Shorter pulses are ignored, and one low pulse yields at most one request.
- R11: After an accepted hardware request at edge E, the STORE starts at edge E+k. Here k is the smallest count of at least HW_MIN at which `ce_n` is sampled high, or HW_MAX if that comes first. `copy_start` is visible after edge E+k.
- R12: While `pwr_good` is low, neither software commands nor hardware requests are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Host chip enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| we_n | input | 1 | Host write enable, active low |
| addr | input | AW | Host address |
| pwr_good | input | 1 | Supply above switch threshold |
| hw_store_n | input | 1 | Hardware store request, active low |
| copy_done | input | 1 | Copy engine finished the current operation |
| busy | output | 1 | Operation accepted or running; host locked out |
| copy_start | output | 1 | One-cycle start pulse to the copy engine |
| copy_dir | output | 1 | 1 = STORE (array to shadow), 0 = RECALL |

## Verification
The bench builds the block with an 8-bit address, SW_LAT=4, HW_PULSE_MIN=3, HW_MIN=3 and HW_MAX=8. With these values every break point of the six-read matcher can be swept, against every kind of breaking cycle. Every release point of the hardware grace window can be swept as well, from before the minimum to past the maximum, and so can every pulse width around the filter threshold. The short delays let the start cycle be predicted exactly and compared against the arithmetic in R4 and R11 for each case.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SW_WAIT,
    ST_HW_WAIT,
    ST_START,
    ST_RUN
  } nvs_state_e;

  typedef enum logic {
    OP_RECALL = 1'b0,
    OP_STORE  = 1'b1
  } nvs_op_e;

  // Grace window decision for a hardware store: leave once the minimum has
  // elapsed and the host bus is idle, or unconditionally at the maximum.
  function automatic logic grace_release(input int unsigned elapsed,
                                         input int unsigned gmin,
                                         input int unsigned gmax,
                                         input logic        bus_idle);
    return ((elapsed >= gmin) && bus_idle) || (elapsed >= gmax);
  endfunction

  // Widest value a shared wait counter must hold.
  function automatic int unsigned wider(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvs_bus_monitor.sv
module nvs_bus_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic rd_evt,
  output logic wr_evt
);

  logic rd_act, wr_act;
  logic rd_prev, wr_prev;

  // A read needs both enables active with write enable released; whichever
  // enable falls last completes it. A write is chip enable with write enable.
  assign rd_act = !ce_n && !oe_n && we_n;
  assign wr_act = !ce_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev <= 1'b0;
      wr_prev <= 1'b0;
    end else begin
      rd_prev <= rd_act;
      wr_prev <= wr_act;
    end
  end

  assign rd_evt = rd_act && !rd_prev;
  assign wr_evt = wr_act && !wr_prev;

endmodule

// File: rtl/nvs_seq_matcher.sv
module nvs_seq_matcher #(
  parameter int unsigned AW      = 16,
  parameter int unsigned SEQ_LEN = 6,
  parameter logic [(SEQ_LEN-1)*AW-1:0] PREFIX = '0,
  parameter logic [AW-1:0] STORE_ADDR  = '0,
  parameter logic [AW-1:0] RECALL_ADDR = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rd_evt,
  input  logic          wr_evt,
  input  logic [AW-1:0] addr,
  output logic          cmd_store,
  output logic          cmd_recall
);

  localparam int unsigned SW   = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1;
  localparam int unsigned LAST = SEQ_LEN - 1;

  logic [SW-1:0]      step_q;
  logic [SEQ_LEN-1:0] hit;
  logic               at_last;

  // One comparator per prefix step; the final slot never matches a prefix.
  for (genvar i = 0; i < SEQ_LEN - 1; i++) begin : g_hit
    assign hit[i] = (addr == PREFIX[i*AW +: AW]);
  end
  assign hit[SEQ_LEN-1] = 1'b0;

  assign at_last = (step_q == SW'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (!en || wr_evt) begin
      step_q <= '0;
    end else if (rd_evt) begin
      if (!at_last && hit[step_q]) step_q <= step_q + SW'(1);
      else                         step_q <= '0;
    end
  end

  assign cmd_store  = en && rd_evt && at_last && (addr == STORE_ADDR);
  assign cmd_recall = en && rd_evt && at_last && (addr == RECALL_ADDR);

endmodule

// File: rtl/nvs_hw_filter.sv
module nvs_hw_filter #(
  parameter int unsigned PULSE_MIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_n,
  output logic req
);

  localparam int unsigned LW = $clog2(PULSE_MIN + 1);

  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           lo_cnt <= '0;
    else if (hw_n)                        lo_cnt <= '0;
    else if (lo_cnt != LW'(PULSE_MIN))    lo_cnt <= lo_cnt + LW'(1);
  end

  // Fires on the low sample that completes the minimum width, once per pulse.
  assign req = !hw_n && (lo_cnt == LW'(PULSE_MIN - 1));

endmodule

// File: rtl/nvsram_seq_ctrl.sv
module nvsram_seq_ctrl
  import nvs_pkg::*;
#(
  parameter int unsigned AW           = 16,
  parameter logic [AW-1:0] SEQ_ADDR0   = 16'h2B71,
  parameter logic [AW-1:0] SEQ_ADDR1   = 16'h90C4,
  parameter logic [AW-1:0] SEQ_ADDR2   = 16'h5E0D,
  parameter logic [AW-1:0] SEQ_ADDR3   = 16'hA3F6,
  parameter logic [AW-1:0] SEQ_ADDR4   = 16'h1C88,
  parameter logic [AW-1:0] STORE_ADDR  = 16'h7D42,
  parameter logic [AW-1:0] RECALL_ADDR = 16'hE619,
  parameter int unsigned SW_LAT       = 7000,
  parameter int unsigned HW_PULSE_MIN = 2,
  parameter int unsigned HW_MIN       = 100,
  parameter int unsigned HW_MAX       = 7000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          pwr_good,
  input  logic          hw_store_n,
  input  logic          copy_done,
  output logic          busy,
  output logic          copy_start,
  output logic          copy_dir
);

  localparam int unsigned SEQ_LEN = 6;
  localparam int unsigned CNT_TOP = wider(SW_LAT, HW_MAX);
  localparam int unsigned CW      = $clog2(CNT_TOP + 1);
  localparam logic [(SEQ_LEN-1)*AW-1:0] PREFIX =
    {SEQ_ADDR4, SEQ_ADDR3, SEQ_ADDR2, SEQ_ADDR1, SEQ_ADDR0};

  nvs_state_e    state_q, state_d;
  nvs_op_e       op_q, op_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pwr_q;
  logic          written_q;

  // Named internal events, also observed by the bound checker.
  logic rd_evt, wr_evt;
  logic cmd_store, cmd_recall;
  logic hw_req;
  logic pwr_rise, pwr_fall;
  logic host_live;
  logic op_run;
  logic op_end;

  assign pwr_rise  = pwr_good && !pwr_q;
  assign pwr_fall  = !pwr_good && pwr_q;
  assign host_live = (state_q == ST_IDLE) && pwr_good && pwr_q;
  assign op_run    = (state_q == ST_RUN);
  assign op_end    = op_run && copy_done;

  nvs_bus_monitor u_bus (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .rd_evt (rd_evt),
    .wr_evt (wr_evt)
  );

  nvs_seq_matcher #(
    .AW          (AW),
    .SEQ_LEN     (SEQ_LEN),
    .PREFIX      (PREFIX),
    .STORE_ADDR  (STORE_ADDR),
    .RECALL_ADDR (RECALL_ADDR)
  ) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (host_live),
    .rd_evt     (rd_evt),
    .wr_evt     (wr_evt),
    .addr       (addr),
    .cmd_store  (cmd_store),
    .cmd_recall (cmd_recall)
  );

  nvs_hw_filter #(
    .PULSE_MIN (HW_PULSE_MIN)
  ) u_hwf (
    .clk   (clk),
    .rst_n (rst_n),
    .hw_n  (hw_store_n),
    .req   (hw_req)
  );

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (pwr_rise) begin
          state_d = ST_START;
          op_d    = OP_RECALL;
        end else if (pwr_fall) begin
          if (written_q) begin
            state_d = ST_START;
            op_d    = OP_STORE;
          end
        end else if (host_live) begin
          if (hw_req && written_q) begin
            state_d = ST_HW_WAIT;
            op_d    = OP_STORE;
          end else if (cmd_store && written_q) begin
            state_d = ST_SW_WAIT;
            op_d    = OP_STORE;
          end else if (cmd_recall) begin
            state_d = ST_SW_WAIT;
            op_d    = OP_RECALL;
          end
        end
      end
      ST_SW_WAIT: begin
        if (cnt_q == CW'(SW_LAT - 1)) state_d = ST_START;
        else                          cnt_d   = cnt_q + CW'(1);
      end
      ST_HW_WAIT: begin
        if (grace_release(32'(cnt_q) + 32'd1, HW_MIN, HW_MAX, ce_n)) state_d = ST_START;
        else                                                         cnt_d   = cnt_q + CW'(1);
      end
      ST_START: state_d = ST_RUN;
      ST_RUN:   if (copy_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_RECALL;
      cnt_q     <= '0;
      pwr_q     <= 1'b0;
      written_q <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      cnt_q   <= cnt_d;
      pwr_q   <= pwr_good;
      if (op_end)                    written_q <= 1'b0;
      else if (host_live && wr_evt)  written_q <= 1'b1;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign copy_start = (state_q == ST_START);
  assign copy_dir   = (op_q == OP_STORE);

endmodule

// File: rtl/nvs_seq_ctrl_chk.sv
module nvs_seq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic copy_done,
  input logic busy,
  input logic copy_start,
  input logic copy_dir,
  input logic host_live,
  input logic cmd_store,
  input logic pwr_rise,
  input logic pwr_fall,
  input logic written_q,
  input logic op_end
);

  a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start |=> !copy_start);

  a_r6_start_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start |-> busy);

  a_r6_busy_ends_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(copy_done));

  a_r6_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(copy_dir));

  a_r5_clean_store_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (host_live && cmd_store && !written_q) |=> !busy);

  a_r5_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    op_end |=> !written_q);

  a_r7_flag_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_end) |=> $stable(written_q));

  a_r8_powerup_recall: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_rise && !busy) |=> (copy_start && !copy_dir));

  a_r9_autostore: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_fall && !busy && written_q) |=> (copy_start && copy_dir));

  a_r9_no_autostore: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_fall && !busy && !written_q) |=> !busy);

  a_r12_power_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good && !busy && !pwr_fall) |=> !busy);

endmodule

bind nvsram_seq_ctrl nvs_seq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_good   (pwr_good),
  .copy_done  (copy_done),
  .busy       (busy),
  .copy_start (copy_start),
  .copy_dir   (copy_dir),
  .host_live  (host_live),
  .cmd_store  (cmd_store),
  .pwr_rise   (pwr_rise),
  .pwr_fall   (pwr_fall),
  .written_q  (written_q),
  .op_end     (op_end)
);

// File: tb/nvsram_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module nvsram_seq_ctrl_tb_top;

  localparam int AW   = 8;
  localparam int SLAT = 4;
  localparam int PMIN = 3;
  localparam int HMIN = 3;
  localparam int HMAX = 8;
  localparam logic [7:0] A_ST = 8'h66;
  localparam logic [7:0] A_RC = 8'hB1;
  localparam logic [7:0] PRE [5] = '{8'h13, 8'h5A, 8'hC2, 8'h27, 8'h9D};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic pwr_good = 1'b0, hw_store_n = 1'b1, copy_done = 1'b0;
  logic busy, copy_start, copy_dir;

  int errs = 0;
  int chks = 0;

  always #2 clk = ~clk;

  nvsram_seq_ctrl #(
    .AW(AW), .SEQ_ADDR0(PRE[0]), .SEQ_ADDR1(PRE[1]), .SEQ_ADDR2(PRE[2]),
    .SEQ_ADDR3(PRE[3]), .SEQ_ADDR4(PRE[4]), .STORE_ADDR(A_ST), .RECALL_ADDR(A_RC),
    .SW_LAT(SLAT), .HW_PULSE_MIN(PMIN), .HW_MIN(HMIN), .HW_MAX(HMAX)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
    .pwr_good(pwr_good), .hw_store_n(hw_store_n), .copy_done(copy_done),
    .busy(busy), .copy_start(copy_start), .copy_dir(copy_dir)
  );

  task automatic check(input string req, input int act, input int exp);
    chks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  endtask

  // Read cycle held for 'hold' cycles; oe_mode keeps ce_n low and strobes oe_n.
  task automatic rd(input logic [7:0] a, input int hold, input bit oe_mode);
    @(negedge clk);
    addr = a; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    repeat (hold) @(negedge clk);
    oe_n = 1'b1;
    if (!oe_mode) ce_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input bit with_oe);
    @(negedge clk);
    addr = a; ce_n = 1'b0; we_n = 1'b0; oe_n = !with_oe;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic idle_bus();
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic seq6(input logic [7:0] last, input int hold, input bit oe_mode);
    for (int i = 0; i < 5; i++) rd(PRE[i], hold, oe_mode);
    rd(last, hold, oe_mode);
  endtask

  task automatic wait_start(input int lim, output int n);
    n = 0;
    while (!copy_start && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic quiet(input string req, input int cyc);
    int b = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (busy || copy_start) b++;
    end
    check(req, b, 0);
  endtask

  task automatic finish_op(input string req);
    check({req, " busy held before done"}, busy, 1);
    @(negedge clk); copy_done = 1'b1;
    @(negedge clk); copy_done = 1'b0;
    check({req, " busy released after done"}, busy, 0);
  endtask

  // Hardware trial: pulse width w; if ce_hold, a read stays in progress and
  // ce_n is released at negedge PMIN+r.
  task automatic hw_trial(input int w, input int r, input bit ce_hold,
                          input bit write_first, output int seen, output int dir_s);
    if (write_first) wr(8'h40, 1'b0);
    if (ce_hold) begin
      @(negedge clk);
      addr = 8'h00; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    end
    @(negedge clk);
    hw_store_n = 1'b0;
    seen = 0;
    dir_s = -1;
    for (int j = 1; j <= PMIN + HMAX + 6; j++) begin
      @(negedge clk);
      if (j == w) hw_store_n = 1'b1;
      if (ce_hold && j == PMIN + r) begin ce_n = 1'b1; oe_n = 1'b1; end
      if (copy_start && seen == 0) begin seen = j; dir_s = copy_dir; end
    end
    hw_store_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    chks++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    report();
  end

  initial begin
    int n, seen, ds, ek;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 copy_start after reset", copy_start, 0);
    rst_n = 1'b1;
    quiet("R1 quiet with no event", 6);

    // R8: power-up recall on the next cycle
    @(negedge clk); pwr_good = 1'b1;
    @(negedge clk);
    check("R8 copy_start after rise", copy_start, 1);
    check("R8 direction recall", copy_dir, 0);
    @(negedge clk);
    check("R6 start pulse one cycle", copy_start, 0);
    finish_op("R6 power-up");

    // R2/R4: software recall, CE and OE qualified, several hold lengths
    for (int mode = 0; mode < 2; mode++) begin
      for (int hold = 1; hold <= 3; hold++) begin
        seq6(A_RC, hold, mode[0]);
        check("R4 busy right after sixth read", busy, 1);
        wait_start(40, n);
        check("R4 software latency", n, SLAT - hold + 1);
        check("R2 recall direction", copy_dir, 0);
        idle_bus();
        finish_op("R6 software recall");
      end
    end

    // R5: software store with clean array is dropped
    seq6(A_ST, 1, 1'b0);
    quiet("R5 clean software store dropped", SLAT + 6);

    // R2/R5: write then software store
    wr(8'h40, 1'b0);
    seq6(A_ST, 1, 1'b0);
    wait_start(40, n);
    check("R2 store latency", n, SLAT);
    check("R2 store direction", copy_dir, 1);
    finish_op("R6 software store");
    seq6(A_ST, 1, 1'b0);
    quiet("R5 flag cleared by completed store", SLAT + 6);

    // R3: break the sequence at every step with every kind of breaking cycle
    for (int k = 0; k < 6; k++) begin
      for (int kind = 0; kind < 3; kind++) begin
        for (int i = 0; i < k; i++) rd(PRE[i], 1, 1'b0);
        if (kind == 0)      rd(((k < 5) ? PRE[k] : A_RC) ^ 8'h01, 1, 1'b0);
        else if (kind == 1) wr(8'h40, 1'b0);
        else                wr(8'h41, 1'b1);
        for (int i = k + 1; i < 6; i++) rd((i < 5) ? PRE[i] : A_RC, 1, 1'b0);
        quiet("R3 broken sequence has no effect", SLAT + 4);
        seq6(A_RC, 1, 1'b0);
        wait_start(40, n);
        check("R3 matcher restarts cleanly", n, SLAT);
        finish_op("R6 recall after break");
      end
    end
    // R3: breaking read at SEQ_ADDR0 does not count as step one
    rd(PRE[0], 1, 1'b0); rd(PRE[1], 1, 1'b0); rd(PRE[0], 1, 1'b0);
    for (int i = 1; i < 5; i++) rd(PRE[i], 1, 1'b0);
    rd(A_RC, 1, 1'b0);
    quiet("R3 breaking read not counted", SLAT + 4);

    // R7: host ignored while busy
    seq6(A_RC, 1, 1'b0);
    wait_start(40, n);
    wr(8'h22, 1'b0);
    wr(8'h23, 1'b0);
    seq6(A_RC, 1, 1'b0);
    idle_bus();
    finish_op("R7 locked recall");
    quiet("R7 reads during busy did not arm", SLAT + 4);
    seq6(A_ST, 1, 1'b0);
    quiet("R7 writes during busy not recorded", SLAT + 4);

    // R10/R11: pulse width sweep with idle bus
    for (int w = 1; w <= PMIN + 2; w++) begin
      hw_trial(w, 0, 1'b0, 1'b1, seen, ds);
      check("R10 pulse filter start", seen, (w < PMIN) ? 0 : PMIN + HMIN);
      if (seen != 0) begin
        check("R10 hardware store direction", ds, 1);
        finish_op("R6 hardware store");
      end
    end
    // R11: grace window sweep over the release point
    for (int r = 0; r <= HMAX + 1; r++) begin
      hw_trial(PMIN, r, 1'b1, 1'b1, seen, ds);
      ek = (r + 1 > HMIN) ? r + 1 : HMIN;
      if (ek > HMAX) ek = HMAX;
      check("R11 grace release cycle", seen, PMIN + ek);
      if (seen != 0) finish_op("R6 grace store");
    end
    // R5: hardware store with clean array is dropped
    hw_trial(PMIN, 0, 1'b0, 1'b0, seen, ds);
    check("R5 clean hardware store dropped", seen, 0);
    // R10: one request per low pulse
    wr(8'h40, 1'b0);
    @(negedge clk); hw_store_n = 1'b0;
    wait_start(40, n);
    check("R10 held pulse starts", n, PMIN + HMIN);
    finish_op("R6 held pulse store");
    wr(8'h41, 1'b0);
    quiet("R10 no second request from one pulse", 10);
    @(negedge clk); hw_store_n = 1'b1;

    // R9: autostore on falling supply
    @(negedge clk); pwr_good = 1'b0;
    @(negedge clk);
    check("R9 autostore start", copy_start, 1);
    check("R9 autostore direction", copy_dir, 1);
    finish_op("R6 autostore");

    // R12: no command accepted with supply low
    seq6(A_RC, 1, 1'b0);
    quiet("R12 command ignored while power low", SLAT + 4);

    // R8: rise again, recall regardless of flag
    @(negedge clk); pwr_good = 1'b1;
    @(negedge clk);
    check("R8 second power-up recall", copy_start, 1);
    finish_op("R6 second power-up");

    // R9: fall with clean array does nothing
    @(negedge clk); pwr_good = 1'b0;
    quiet("R9 no autostore when clean", 6);

    report();
  end

endmodule